// File: doc/BRIEF.md
# Charge Pulse Sequencer and Averager

This block sets when an external RC delay network starts charging and measures how long the charge takes to reach the comparator threshold. A 100 µs tick strobe drives a position counter that wraps once per second. On the tick where that position equals a programmed start value, the block raises its charge output and clears a 16-bit duration timer. The timer then advances on every 3.2 µs enable strobe. The first rising edge from the comparator after that ends the charge and freezes the timer. A comparator edge that arrives while no charge is pending is reported as a reference pulse instead.

Completed charge durations are summed eight at a time into a 24-bit register. The top 16 bits of the sum are kept, which averages the eight readings and rescales them from 3.2 µs units to roughly 102.4 µs units. The most recent average is copied to the charge-length output once every eight seconds. At startup, a calibration request runs one charge with the external trigger blocked and flags a fault if the measured time falls outside configured limits. A charge that never sees the comparator is stopped when the timer saturates.

Top module: `charge_seq`

## Requirements
- R1: After reset, charge_o, trig_block_o, ref_evt_o, cal_done_o, cal_fault_o and timeout_o are 0, and dur_o and chg_len_o are 0.
- R2: On a tick_i strobe where the tick position (counting 0 to TICKS_PER_SEC-1 since reset, advancing on each tick) equals start_val_i, and no charge is running, charge_o rises and dur_o reads 0 in the next cycle.
- R3: While a charge is running, dur_o increases by exactly one for each cycle in which tmr_en_i is high.
- R4: cmp_i is passed through a two-flop synchroniser. Its first rising edge during a charge drops charge_o, and dur_o then holds its value through any later tmr_en_i strobes until the next charge starts.
- R5: A rising edge of cmp_i while no charge is running produces a single-cycle ref_evt_o pulse and changes neither charge_o nor dur_o.
- R6: Each normally completed (non-calibration) charge adds its final duration to a 24-bit sum. After the eighth such sample, bits 23:8 of the sum become the stored average, and the sum and sample count restart from zero.
- R7: chg_len_o loads the stored average only on the tick that closes every SECS_PER_PUB-th second (the tick at position TICKS_PER_SEC-1 of seconds 7, 15, ... for the default of 8). At all other times it holds its value.
- R8: A cal_req_i pulse while idle raises charge_o and trig_block_o and restarts the timer. When that charge ends, trig_block_o falls and cal_done_o is set. cal_fault_o is set when the duration is below CAL_MIN or above CAL_MAX (both inclusive limits pass) or the charge timed out. A calibration charge adds no sample to the sum.
- R9: If a running charge reaches a duration of 16'hFFFF, it ends in the next cycle with timeout_o set and its sample discarded. timeout_o clears when the next charge starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 100 µs tick strobe |
| tmr_en_i | input | 1 | 3.2 µs duration timer enable strobe |
| start_val_i | input | SUB_W | Tick position at which a charge starts |
| cal_req_i | input | 1 | Calibration charge request pulse |
| cmp_i | input | 1 | Asynchronous comparator output |
| charge_o | output | 1 | Drives the RC network charge |
| trig_block_o | output | 1 | Blocks the external reference trigger during calibration |
| dur_o | output | 16 | Duration timer value |
| ref_evt_o | output | 1 | Comparator edge seen with no charge pending |
| chg_len_o | output | 16 | Published averaged charge length |
| cal_done_o | output | 1 | Calibration charge finished |
| cal_fault_o | output | 1 | Calibration result outside limits or timed out |
| timeout_o | output | 1 | Last charge ended on timer saturation |

## Verification
On every cycle the assertions check the following: a charge starts with a cleared timer, the timer steps by one per strobe and freezes when idle, the sample count stays in range, chg_len_o moves only on publish ticks, saturation ends a charge with timeout set, and reference pulses last a single cycle. The bench scenarios are the only way to show end-to-end values. These are the average of eight distinct durations with truncation, the exact tick on which it is published, the calibration limit decision for passing and failing durations, and calibration samples staying out of the average.

// File: rtl/charge_pkg.sv
package charge_pkg;
  localparam int TMR_W = 16;
  localparam int ACC_W = 24;
  localparam int DROP_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_CAL  = 2'd2
  } cs_state_e;
endpackage

// File: rtl/cs_sync.sv
module cs_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cs_timebase.sv
module cs_timebase #(
  parameter int TICKS_PER_SEC = 10000,
  parameter int SECS_PER_PUB  = 8,
  localparam int SUB_W = $clog2(TICKS_PER_SEC),
  localparam int SEC_W = (SECS_PER_PUB > 1) ? $clog2(SECS_PER_PUB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SUB_W-1:0] start_val_i,
  output logic             match_o,
  output logic             pub_o
);
  logic [SUB_W-1:0] sub_q;
  logic [SEC_W-1:0] sec_q;
  logic sub_last, sec_last;

  assign sub_last = (sub_q == SUB_W'(TICKS_PER_SEC - 1));
  assign sec_last = (sec_q == SEC_W'(SECS_PER_PUB - 1));
  assign match_o  = tick_i && (sub_q == start_val_i);
  assign pub_o    = tick_i && sub_last && sec_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      sec_q <= '0;
    end else if (tick_i) begin
      if (sub_last) begin
        sub_q <= '0;
        sec_q <= sec_last ? '0 : sec_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  a_r2_sub_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= SUB_W'(TICKS_PER_SEC - 1));
endmodule

// File: rtl/cs_avg.sv
module cs_avg
  import charge_pkg::*;
#(
  parameter int NSAMP = 8,
  localparam int CNT_W = (NSAMP > 1) ? $clog2(NSAMP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_v_i,
  input  logic [TMR_W-1:0] smp_i,
  output logic [TMR_W-1:0] avg_o
);
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign acc_nxt = acc_q + ACC_W'(smp_i);
  assign last    = (cnt_q == CNT_W'(NSAMP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      avg_o <= '0;
    end else if (smp_v_i) begin
      if (last) begin
        avg_o <= acc_nxt[ACC_W-1 -: TMR_W];
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= acc_nxt;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NSAMP - 1));
  a_r6_avg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_v_i |=> $stable(avg_o));
endmodule

// File: rtl/charge_seq.sv
module charge_seq
  import charge_pkg::*;
#(
  parameter int TICKS_PER_SEC = 10000,
  parameter int SECS_PER_PUB  = 8,
  parameter int NSAMP         = 8,
  parameter int CAL_MIN       = 1000,
  parameter int CAL_MAX       = 20000,
  localparam int SUB_W = $clog2(TICKS_PER_SEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tmr_en_i,
  input  logic [SUB_W-1:0] start_val_i,
  input  logic             cal_req_i,
  input  logic             cmp_i,
  output logic             charge_o,
  output logic             trig_block_o,
  output logic [TMR_W-1:0] dur_o,
  output logic             ref_evt_o,
  output logic [TMR_W-1:0] chg_len_o,
  output logic             cal_done_o,
  output logic             cal_fault_o,
  output logic             timeout_o
);
  cs_state_e        st_q;
  logic [TMR_W-1:0] tmr_q, avg;
  logic cmp_rise, match, pub;
  logic busy, sat, start_run, start_cal, end_ok, end_to, in_lim;

  cs_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .async_i(cmp_i), .rise_o(cmp_rise));

  cs_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_PUB(SECS_PER_PUB)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .start_val_i(start_val_i),
    .match_o(match), .pub_o(pub));

  assign busy      = (st_q != ST_IDLE);
  assign sat       = (tmr_q == {TMR_W{1'b1}});
  assign start_run = match && !busy;
  assign start_cal = cal_req_i && !busy && !match;
  assign end_ok    = busy && cmp_rise;
  assign end_to    = busy && !cmp_rise && sat;
  assign in_lim    = (tmr_q >= TMR_W'(CAL_MIN)) && (tmr_q <= TMR_W'(CAL_MAX));

  cs_avg #(.NSAMP(NSAMP)) u_avg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .smp_v_i(end_ok && st_q == ST_RUN), .smp_i(tmr_q), .avg_o(avg));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      tmr_q       <= '0;
      ref_evt_o   <= 1'b0;
      chg_len_o   <= '0;
      cal_done_o  <= 1'b0;
      cal_fault_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      ref_evt_o <= cmp_rise && !busy;
      if (pub) chg_len_o <= avg;
      if (start_run || start_cal) begin
        st_q      <= start_run ? ST_RUN : ST_CAL;
        tmr_q     <= '0;
        timeout_o <= 1'b0;
        if (start_cal) begin
          cal_done_o  <= 1'b0;
          cal_fault_o <= 1'b0;
        end
      end else if (end_ok || end_to) begin
        st_q <= ST_IDLE;
        if (end_to) timeout_o <= 1'b1;
        if (st_q == ST_CAL) begin
          cal_done_o  <= 1'b1;
          cal_fault_o <= end_to || !in_lim;
        end
      end else if (busy && tmr_en_i && !sat) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign charge_o     = busy;
  assign trig_block_o = (st_q == ST_CAL);
  assign dur_o        = tmr_q;

  a_r2_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !charge_o) |=> (charge_o && dur_o == '0));
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_o && tmr_en_i && !cmp_rise && dur_o != {TMR_W{1'b1}}) |=> dur_o == $past(dur_o) + 1'b1);
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!charge_o && !match && !cal_req_i) |=> $stable(dur_o));
  a_r4_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_o && cmp_rise) |=> !charge_o);
  a_r5_ref_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_evt_o |=> !ref_evt_o);
  a_r7_pub_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pub |=> $stable(chg_len_o));
  a_r8_block_cal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_block_o |-> charge_o);
  a_r9_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_o && !cmp_rise && dur_o == {TMR_W{1'b1}}) |=> (!charge_o && timeout_o));
endmodule

// File: tb/charge_seq_test.sv
module charge_seq_test;
  localparam int TPS = 20;
  localparam int SUB_W = $clog2(TPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, tmr_en = 1'b0, cal_req = 1'b0, cmp = 1'b0;
  logic [SUB_W-1:0] start_val = SUB_W'(3);
  logic charge, trig_block, ref_evt, cal_done, cal_fault, timeout;
  logic [15:0] dur, chg_len;

  int total = 0, bad = 0, tk = 0, ref_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  charge_seq #(.TICKS_PER_SEC(TPS), .SECS_PER_PUB(8), .NSAMP(8),
               .CAL_MIN(100), .CAL_MAX(1000)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tmr_en_i(tmr_en),
    .start_val_i(start_val), .cal_req_i(cal_req), .cmp_i(cmp),
    .charge_o(charge), .trig_block_o(trig_block), .dur_o(dur),
    .ref_evt_o(ref_evt), .chg_len_o(chg_len), .cal_done_o(cal_done),
    .cal_fault_o(cal_fault), .timeout_o(timeout));

  always @(negedge clk) if (ref_evt) ref_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; step(); tick = 1'b0; tk++;
  endtask

  task automatic ticks_to(input int idx);
    while (tk <= idx) do_tick();
  endtask

  task automatic pulse_en(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_en = 1'b1; step(); tmr_en = 1'b0; step();
    end
  endtask

  task automatic fire_cmp();
    cmp = 1'b1; step(5); cmp = 1'b0; step(4);
  endtask

  task automatic t_reset();
    chk("R1 charge", charge, 0);
    chk("R1 trig_block", trig_block, 0);
    chk("R1 ref_evt", ref_evt, 0);
    chk("R1 cal_done", cal_done, 0);
    chk("R1 cal_fault", cal_fault, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 dur", dur, 0);
    chk("R1 chg_len", chg_len, 0);
  endtask

  task automatic t_cal(input int n, input bit exp_fault);
    cal_req = 1'b1; step(); cal_req = 1'b0;
    chk("R8 cal charge", charge, 1);
    chk("R8 trig_block on", trig_block, 1);
    chk("R8 dur cleared", dur, 0);
    pulse_en(n);
    fire_cmp();
    chk("R8 charge off", charge, 0);
    chk("R8 trig_block off", trig_block, 0);
    chk("R8 cal_done", cal_done, 1);
    chk("R8 cal_fault", cal_fault, exp_fault);
    chk("R8 no ref evt", ref_cnt, 0);
  endtask

  task automatic t_sample(input int k, input int n);
    ticks_to(TPS * k + 2);
    chk("R2 no early charge", charge, 0);
    do_tick();
    chk("R2 charge start", charge, 1);
    chk("R2 dur cleared", dur, 0);
    pulse_en(n);
    chk("R3 dur count", dur, n);
    fire_cmp();
    chk("R4 charge off", charge, 0);
    chk("R4 dur final", dur, n);
  endtask

  task automatic t_hold_and_ref();
    int d0;
    d0 = dur;
    pulse_en(5);
    chk("R4 dur held", dur, d0);
    fire_cmp();
    chk("R5 ref pulse count", ref_cnt, 1);
    chk("R5 charge unchanged", charge, 0);
    chk("R5 dur unchanged", dur, d0);
  endtask

  task automatic t_publish();
    ticks_to(8 * TPS - 2);
    chk("R7 before publish", chg_len, 0);
    do_tick();
    // durations 300..1000 sum to 5200; 5200>>8 = 20
    chk("R7 R6 published avg", chg_len, 20);
    do_tick();
    chk("R7 held", chg_len, 20);
  endtask

  task automatic t_timeout();
    ticks_to(8 * TPS + 3);
    chk("R9 charge start", charge, 1);
    tmr_en = 1'b1; step(65540); tmr_en = 1'b0; step();
    chk("R9 charge off", charge, 0);
    chk("R9 timeout", timeout, 1);
    chk("R9 dur saturated", dur, 16'hFFFF);
    ticks_to(9 * TPS + 3);
    chk("R9 timeout cleared", timeout, 0);
    pulse_en(4);
    fire_cmp();
    ticks_to(16 * TPS - 1);
    chk("R9 R6 timed-out sample discarded", chg_len, 20);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_cal(50, 1);
    t_cal(200, 0);
    t_cal(1001, 1);
    for (int k = 0; k < 8; k++) begin
      t_sample(k, 300 + 100 * k);
      if (k == 0) t_hold_and_ref();
    end
    t_publish();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule